// File: doc/BRIEF.md
# Differential Escalation Sender with Line Test

This block drives one escalation link toward a remote countermeasure receiver. The link is fully synchronous and has two differential pairs. The sender drives a command pair (`cmd_p_o`/`cmd_n_o`) and watches a response pair (`rsp_p_i`/`rsp_n_i`) that the receiver drives back. The length of the pulse on the command pair tells the receiver what kind of message it is. A line test ("ping") is a pulse one cycle long. An escalation is a pulse one cycle longer than the request that caused it.

The sender also checks that the receiver answers correctly. A ping must be answered with a fixed alternating burst that starts exactly one cycle after the pulse. During an escalation, the response must toggle every cycle. The response pair must always be complementary. Any wrong, missing, early or non-complementary answer produces a one-cycle `link_fault_o` pulse. A correct ping answer produces a one-cycle `ping_done_o` pulse.

Escalation always wins over line tests. A ping request that is seen while escalation is active is acknowledged at once. A ping still in flight is dropped when escalation starts. The ping timeout is not part of this block.

Top module: `esc_link_sender`

## Requirements
- R1: During and after synchronous reset with no requests, `cmd_p_o` is 0, `cmd_n_o` is 1, `ping_done_o` is 0 and `link_fault_o` is 0. In every cycle after reset, `cmd_n_o` is the complement of `cmd_p_o`.
- R2: An escalation request held high for N consecutive sampled cycles (N > 0) with no ping running gives a `cmd_p_o` pulse exactly N+1 cycles long. The pulse starts in the cycle after the first sampled request.
- R3: A new ping request, seen with no escalation active, gives a `cmd_p_o` pulse exactly one cycle long. The pulse starts in the cycle after the request is first sampled.
- R4: After a ping pulse in cycle k, the response `rsp_p_i` must read 0 in cycle k and then 1,0,1,0 in cycles k+1 to k+4 (RESP_LEN=4), with `rsp_n_i` its complement. When it does, `ping_done_o` pulses once, in cycle k+5.
- R5: If the ping response is early (1 in cycle k), missing, or differs at any step, `link_fault_o` pulses exactly once in the cycle after the first bad sample. `ping_done_o` stays low, and that request is not retried while `ping_req_i` stays high.
- R6: For every cycle c in which the command pulse is high because of an escalation, `rsp_p_i` in cycle c+1 must differ from `rsp_p_i` in cycle c. If it does not, `link_fault_o` pulses in cycle c+2.
- R7: In any cycle where `rsp_p_i` equals `rsp_n_i`, `link_fault_o` is high in the next cycle. A receiver that holds both wires equal and toggles them gives one fault per cycle.
- R8: A ping request first seen while an escalation request is active gives `ping_done_o` in the next cycle and no ping pulse. An escalation that starts during a ping ends that ping without a fault and acknowledges the pending request.
- R9: Each ping request (a high period of `ping_req_i`) gives at most one `ping_done_o` pulse and at most one ping launch. Both `ping_done_o` and `link_fault_o` are registered outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| esc_req_i | input | 1 | Escalation request level |
| ping_req_i | input | 1 | Line-test request, held until answered |
| cmd_p_o | output | 1 | Command pair, true wire |
| cmd_n_o | output | 1 | Command pair, complement wire |
| rsp_p_i | input | 1 | Response pair, true wire |
| rsp_n_i | input | 1 | Response pair, complement wire |
| ping_done_o | output | 1 | One-cycle pulse: line test answered correctly or bypassed by escalation |
| link_fault_o | output | 1 | One-cycle pulse per detected integrity fault |

## Verification
The assertions assume that the reset holds both request inputs low. They also assume that the requests are sampled on the same clock as the sender, so a rise or fall of a request can be related to the command pair one edge later. The bench drives every input on the falling edge from a single thread. It models a well-behaved receiver, and injects faults only by overriding the response pair for chosen cycles. It leaves idle gaps long enough for the receiver model to stop toggling before the next ping starts, so a leftover escalation answer is never read as an early ping response.

// File: rtl/esc_link_pkg.sv
package esc_link_pkg;
  typedef enum logic [1:0] {
    PS_IDLE    = 2'd0,
    PS_LAUNCH  = 2'd1,
    PS_COLLECT = 2'd2
  } ping_st_e;
endpackage

// File: rtl/esc_cmd_gen.sv
module esc_cmd_gen (
  input  logic clk,
  input  logic rst,
  input  logic esc_req_i,
  input  logic ping_fire_i,
  output logic esc_line_o,
  output logic esc_sent_o,
  output logic cmd_p_o,
  output logic cmd_n_o
);
  logic esc_req_d;

  // the delayed copy stretches an N-cycle request into N+1 cycles
  always_comb esc_line_o = esc_req_i | esc_req_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      esc_req_d  <= 1'b0;
      esc_sent_o <= 1'b0;
      cmd_p_o    <= 1'b0;
      cmd_n_o    <= 1'b1;
    end else begin
      esc_req_d  <= esc_req_i;
      esc_sent_o <= esc_line_o;
      cmd_p_o    <= esc_line_o | ping_fire_i;
      cmd_n_o    <= ~(esc_line_o | ping_fire_i);
    end
  end
endmodule

// File: rtl/esc_ping_seq.sv
module esc_ping_seq
  import esc_link_pkg::*;
#(
  parameter int RESP_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic ping_req_i,
  input  logic esc_line_i,
  input  logic rsp_p_i,
  output logic ping_fire_o,
  output logic ping_err_o,
  output logic ping_done_o
);
  localparam int CW = (RESP_LEN > 1) ? $clog2(RESP_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(RESP_LEN - 1);

  ping_st_e        st_q;
  logic [CW-1:0]   step_q;
  logic            served_q;
  logic            exp_bit;

  // the burst starts with 1 and then alternates
  always_comb exp_bit = ~step_q[0];

  always_comb begin
    ping_fire_o = (st_q == PS_IDLE) && ping_req_i && !served_q && !esc_line_i;
    ping_err_o  = 1'b0;
    if (!esc_line_i) begin
      if (st_q == PS_LAUNCH && rsp_p_i)                 ping_err_o = 1'b1;
      if (st_q == PS_COLLECT && (rsp_p_i != exp_bit))   ping_err_o = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= PS_IDLE;
      step_q      <= '0;
      served_q    <= 1'b0;
      ping_done_o <= 1'b0;
    end else begin
      ping_done_o <= 1'b0;
      if (!ping_req_i) served_q <= 1'b0;
      if (esc_line_i) begin
        st_q <= PS_IDLE;
        if (ping_req_i && !served_q) begin
          ping_done_o <= 1'b1;
          served_q    <= 1'b1;
        end
      end else begin
        unique case (st_q)
          PS_IDLE: begin
            if (ping_fire_o) st_q <= PS_LAUNCH;
          end
          PS_LAUNCH: begin
            step_q <= '0;
            if (rsp_p_i) begin
              st_q     <= PS_IDLE;
              served_q <= 1'b1;
            end else begin
              st_q <= PS_COLLECT;
            end
          end
          PS_COLLECT: begin
            if (rsp_p_i != exp_bit) begin
              st_q     <= PS_IDLE;
              served_q <= 1'b1;
            end else if (step_q == LAST) begin
              st_q        <= PS_IDLE;
              served_q    <= 1'b1;
              ping_done_o <= 1'b1;
            end else begin
              step_q <= step_q + 1'b1;
            end
          end
          default: st_q <= PS_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/esc_rsp_mon.sv
module esc_rsp_mon (
  input  logic clk,
  input  logic rst,
  input  logic rsp_p_i,
  input  logic rsp_n_i,
  input  logic esc_sent_i,
  output logic mon_err_o
);
  logic rsp_last_q;
  logic tog_chk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_last_q <= 1'b0;
      tog_chk_q  <= 1'b0;
    end else begin
      rsp_last_q <= rsp_p_i;
      tog_chk_q  <= esc_sent_i;
    end
  end

  always_comb begin
    mon_err_o = (rsp_p_i == rsp_n_i) || (tog_chk_q && (rsp_p_i == rsp_last_q));
  end
endmodule

// File: rtl/esc_link_sender.sv
module esc_link_sender #(
  parameter int RESP_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic esc_req_i,
  input  logic ping_req_i,
  output logic cmd_p_o,
  output logic cmd_n_o,
  input  logic rsp_p_i,
  input  logic rsp_n_i,
  output logic ping_done_o,
  output logic link_fault_o
);
  logic esc_line, esc_sent, ping_fire, ping_err, mon_err;

  esc_cmd_gen u_cmd (
    .clk         (clk),
    .rst         (rst),
    .esc_req_i   (esc_req_i),
    .ping_fire_i (ping_fire),
    .esc_line_o  (esc_line),
    .esc_sent_o  (esc_sent),
    .cmd_p_o     (cmd_p_o),
    .cmd_n_o     (cmd_n_o)
  );

  esc_ping_seq #(.RESP_LEN(RESP_LEN)) u_ping (
    .clk         (clk),
    .rst         (rst),
    .ping_req_i  (ping_req_i),
    .esc_line_i  (esc_line),
    .rsp_p_i     (rsp_p_i),
    .ping_fire_o (ping_fire),
    .ping_err_o  (ping_err),
    .ping_done_o (ping_done_o)
  );

  esc_rsp_mon u_mon (
    .clk        (clk),
    .rst        (rst),
    .rsp_p_i    (rsp_p_i),
    .rsp_n_i    (rsp_n_i),
    .esc_sent_i (esc_sent),
    .mon_err_o  (mon_err)
  );

  always_ff @(posedge clk) begin
    if (rst) link_fault_o <= 1'b0;
    else     link_fault_o <= ping_err | mon_err;
  end
endmodule

// File: rtl/esc_link_sender_chk.sv
module esc_link_sender_chk (
  input logic clk,
  input logic rst,
  input logic esc_req_i,
  input logic ping_req_i,
  input logic cmd_p_o,
  input logic cmd_n_o,
  input logic rsp_p_i,
  input logic rsp_n_i,
  input logic ping_done_o,
  input logic link_fault_o
);
  p_cmd_pair_r1: assert property (@(posedge clk) disable iff (rst)
    cmd_p_o != cmd_n_o);

  p_esc_follow_r2: assert property (@(posedge clk) disable iff (rst)
    esc_req_i |=> cmd_p_o);

  p_esc_tail_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(esc_req_i) |=> cmd_p_o);

  p_ping_single_r3: assert property (@(posedge clk) disable iff (rst)
    ($rose(cmd_p_o) && !$past(esc_req_i)) |=> (cmd_p_o == $past(esc_req_i)));

  p_equal_wires_r7: assert property (@(posedge clk) disable iff (rst)
    (rsp_p_i == rsp_n_i) |=> link_fault_o);

  p_bypass_ack_r8: assert property (@(posedge clk) disable iff (rst)
    ($rose(ping_req_i) && esc_req_i) |=> ping_done_o);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    ping_done_o |=> !ping_done_o);
endmodule

bind esc_link_sender esc_link_sender_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .esc_req_i    (esc_req_i),
  .ping_req_i   (ping_req_i),
  .cmd_p_o      (cmd_p_o),
  .cmd_n_o      (cmd_n_o),
  .rsp_p_i      (rsp_p_i),
  .rsp_n_i      (rsp_n_i),
  .ping_done_o  (ping_done_o),
  .link_fault_o (link_fault_o)
);

// File: tb/esc_link_sender_tb.sv
module esc_link_sender_tb;
  localparam time CLK_P = 20ns;

  logic clk = 1'b0;
  always #(CLK_P / 2) clk = ~clk;

  logic rst, esc_req, ping_req;
  logic cmd_p, cmd_n, ping_done, link_fault;
  logic rsp_p, rsp_n;

  // receiver model and fault injection
  logic       m_rp, m_act;
  logic [3:0] m_cnt;
  logic       stall_en, flip_en, ovr_en, ovr_p, ovr_n, flip;
  int         flip_step;

  esc_link_sender u_dut (
    .clk          (clk),
    .rst          (rst),
    .esc_req_i    (esc_req),
    .ping_req_i   (ping_req),
    .cmd_p_o      (cmd_p),
    .cmd_n_o      (cmd_n),
    .rsp_p_i      (rsp_p),
    .rsp_n_i      (rsp_n),
    .ping_done_o  (ping_done),
    .link_fault_o (link_fault)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      m_rp <= 1'b0; m_act <= 1'b0; m_cnt <= '0;
    end else if (cmd_p) begin
      if (!m_act) begin
        m_rp <= 1'b1; m_act <= 1'b1; m_cnt <= 4'd1;
      end else begin
        if (!(stall_en && m_cnt >= 4'd3)) m_rp <= ~m_rp;
        m_cnt <= (m_cnt == 4'd15) ? 4'd15 : m_cnt + 4'd1;
      end
    end else if (m_act && m_cnt < 4'd4) begin
      m_rp <= ~m_rp; m_cnt <= m_cnt + 4'd1;
    end else begin
      m_rp <= 1'b0; m_act <= 1'b0; m_cnt <= '0;
    end
  end

  always_comb begin
    flip  = flip_en && m_act && (m_cnt == 4'(flip_step + 1));
    rsp_p = ovr_en ? ovr_p : (m_rp ^ flip);
    rsp_n = ovr_en ? ovr_n : ~(m_rp ^ flip);
  end

  int n_cmp = 0, n_bad = 0;
  int c_cmd, c_done, c_fault, c_pol, idx, idx_cmd, idx_done;

  task automatic clr();
    c_cmd = 0; c_done = 0; c_fault = 0; c_pol = 0; idx = 0; idx_cmd = -1; idx_done = -1;
  endtask

  task automatic step();
    @(negedge clk);
    idx++;
    if (cmd_p) begin c_cmd++; if (idx_cmd < 0) idx_cmd = idx; end
    if (ping_done) begin c_done++; if (idx_done < 0) idx_done = idx; end
    if (link_fault) c_fault++;
    if (cmd_n === cmd_p) c_pol++;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic idle(input int n);
    repeat (n) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; esc_req = 1'b0; ping_req = 1'b0;
    stall_en = 1'b0; flip_en = 1'b0; ovr_en = 1'b0; ovr_p = 1'b0; ovr_n = 1'b1; flip_step = 0;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk(cmd_p == 1'b0, "R1 cmd_p reset", int'(cmd_p), 0);
    chk(cmd_n == 1'b1, "R1 cmd_n reset", int'(cmd_n), 1);
    chk(ping_done == 1'b0, "R1 ping_done reset", int'(ping_done), 0);
    chk(link_fault == 1'b0, "R1 link_fault reset", int'(link_fault), 0);
    rst = 1'b0;
    clr(); idle(6);
    chk(c_cmd == 0 && c_fault == 0, "R1 idle quiet", c_cmd + c_fault, 0);

    // R2 / R6: escalation length sweep with a healthy receiver
    for (int n = 1; n <= 8; n++) begin
      clr();
      esc_req = 1'b1;
      repeat (n) step();
      esc_req = 1'b0;
      idle(12);
      chk(c_cmd == n + 1, "R2 pulse length", c_cmd, n + 1);
      chk(idx_cmd == 1, "R2 pulse start", idx_cmd, 1);
      chk(c_fault == 0, "R6 toggling accepted", c_fault, 0);
      chk(c_pol == 0, "R1 complement", c_pol, 0);
    end

    // R3 / R4: healthy ping
    clr();
    ping_req = 1'b1;
    idle(8);
    ping_req = 1'b0;
    idle(6);
    chk(c_cmd == 1, "R3 ping pulse length", c_cmd, 1);
    chk(idx_cmd == 1, "R3 ping pulse start", idx_cmd, 1);
    chk(c_done == 1, "R4 ping_done count", c_done, 1);
    chk(idx_done == 6, "R4 ping_done cycle", idx_done, 6);
    chk(c_fault == 0, "R4 no fault", c_fault, 0);

    // R9: request held long after the answer
    clr();
    ping_req = 1'b1;
    idle(20);
    ping_req = 1'b0;
    idle(6);
    chk(c_cmd == 1, "R9 single launch", c_cmd, 1);
    chk(c_done == 1, "R9 single done", c_done, 1);

    // R5: corrupted burst at each step
    for (int s = 0; s < 4; s++) begin
      clr();
      flip_en = 1'b1; flip_step = s;
      ping_req = 1'b1;
      idle(12);
      ping_req = 1'b0; flip_en = 1'b0;
      idle(6);
      chk(c_fault == 1, "R5 corrupted step fault", c_fault, 1);
      chk(c_done == 0, "R5 corrupted step no done", c_done, 0);
      chk(c_cmd == 1, "R5 no retry", c_cmd, 1);
    end

    // R5: early response
    clr();
    ovr_en = 1'b1; ovr_p = 1'b1; ovr_n = 1'b0;
    ping_req = 1'b1;
    idle(8);
    ovr_en = 1'b0; ping_req = 1'b0;
    idle(8);
    chk(c_fault == 1, "R5 early fault", c_fault, 1);
    chk(c_done == 0, "R5 early no done", c_done, 0);

    // R5: missing response
    clr();
    ovr_en = 1'b1; ovr_p = 1'b0; ovr_n = 1'b1;
    ping_req = 1'b1;
    idle(8);
    ovr_en = 1'b0; ping_req = 1'b0;
    idle(8);
    chk(c_fault == 1, "R5 missing fault", c_fault, 1);
    chk(c_done == 0, "R5 missing no done", c_done, 0);

    // R7: equal wires toggled for four cycles
    clr();
    ovr_en = 1'b1;
    for (int i = 0; i < 4; i++) begin
      ovr_p = (i % 2 == 0); ovr_n = ovr_p;
      step();
    end
    ovr_en = 1'b0; ovr_p = 1'b0; ovr_n = 1'b1;
    idle(6);
    chk(c_fault == 4, "R7 repeated fault", c_fault, 4);

    // R6: receiver stops toggling during escalation
    clr();
    stall_en = 1'b1;
    esc_req = 1'b1;
    idle(8);
    esc_req = 1'b0;
    idle(10);
    stall_en = 1'b0;
    idle(4);
    chk(c_fault >= 1, "R6 stalled toggle fault", c_fault, 1);

    // R8: ping requested during escalation
    clr();
    esc_req = 1'b1;
    idle(3);
    ping_req = 1'b1;
    step();
    chk(ping_done == 1'b1, "R8 immediate done", int'(ping_done), 1);
    idle(4);
    esc_req = 1'b0;
    idle(3);
    ping_req = 1'b0;
    idle(10);
    chk(c_done == 1, "R8 single bypass done", c_done, 1);
    chk(c_cmd == 9, "R8 no extra pulse", c_cmd, 9);
    chk(c_fault == 0, "R8 bypass no fault", c_fault, 0);

    // R8: escalation arriving in the middle of a ping
    clr();
    ping_req = 1'b1;
    idle(3);
    esc_req = 1'b1;
    idle(5);
    esc_req = 1'b0;
    idle(8);
    ping_req = 1'b0;
    idle(10);
    chk(c_done == 1, "R8 abort done", c_done, 1);
    chk(c_fault == 0, "R8 abort no fault", c_fault, 0);

    summary();
    $finish;
  end
endmodule